// File: doc/BRIEF.md
# Triggered Memory-to-Memory Transfer Channel

This block is a single channel that copies data from one place on a memory bus to another without the processor. Software programs a source address, a destination address, a unit count and a control word. The channel then waits for a rising edge on one of several trigger lines and moves bytes or 16-bit words. Each unit takes a bus read, and the bus write follows in the next cycle. After every unit, each address can stay where it is, step up or step down. The step is one for bytes and two for words.

There are three transfer kinds, and each can run once or repeat. Single moves one unit per trigger. Block moves the whole count per trigger. Burst-block also moves the whole count, but after every two units it leaves one cycle with the bus released, so the processor keeps one bus cycle in five. In the one-shot variants the enable bit drops when the count runs out. In the repeat variants the enable bit stays set, and the working addresses and count reload from the programmed values. Repeated burst-block starts the next pass on its own, with no trigger. Each time the count runs out, a sticky interrupt flag is raised.

The bus has one master and no wait states. Read data comes back on the cycle after the read request. In byte units the memory returns the addressed byte in bits 7:0.

Top module: `dma_chan`

## Requirements
- R1: After reset, bus_req, bus_we, ch_en and irq are all low. bus_we is never high without bus_req.
- R2: Register writes use cfg_sel: 0 is the source address, 1 the destination address, 2 the unit count (1 to 65535), 3 the control word. The control word has bit 0 enable, bits 2:1 kind (0 single, 1 block, 2 burst-block, 3 acts as single), bit 3 repeat, bit 4 word units, bits 6:5 source step, bits 8:7 destination step, bits 10:9 trigger select, and bit 15 interrupt clear. Writing the control word with bit 0 set while the channel is disabled loads the working addresses and count. In single mode each accepted trigger gives one read cycle at the source and then one write cycle at the destination, carrying the data read.
- R3: In one-shot mode, ch_en drops once the final unit is written. Triggers then cause no bus activity until the control word is written again with enable set.
- R4: In block mode one trigger moves every unit, one after another, with no idle bus cycle between them. Enable then clears.
- R5: In repeated single or block mode, ch_en stays high when the count runs out. The addresses and count reload from the programmed registers, and the next trigger starts again from the programmed addresses.
- R6: In burst-block mode the bus is released for exactly one cycle after every second unit, so there are never more than four bus cycles in a row.
- R7: Repeated burst-block releases the bus for one cycle at the end of each pass and then starts the next pass without a trigger. It stops at the end of the current unit pair once software clears enable.
- R8: Step codes are 0 hold, 1 increment, 2 decrement and 3 hold. Source and destination are set independently. The step is 1 for byte units and 2 for word units.
- R9: Only a rising edge of the selected trigger line starts a transfer. A held-high level, edges on lines that are not selected, and edges that arrive while a unit or block is in progress all have no effect.
- R10: irq is set whenever the count runs out. It stays set through any control write whose bit 15 is 0, and it clears on a control write with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| trig | input | 4 | Trigger request lines |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | Bus cycle is byte sized |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid the cycle after a read |
| ch_en | output | 1 | Channel enable state |
| irq | output | 1 | Sticky completion flag |

## Verification
Most internal faults in this channel show up on the bus within one or two cycles. A wrong address step shows in bus_addr on the next unit. A count that is off by one adds or drops a unit and moves the edge of ch_en and irq. A bad pair counter in burst mode moves or removes the release cycle. The bench keeps a behavioural model of the channel and of memory and compares every bus field, ch_en and irq on every clock. A fault that only misplaces data, such as a stale reload, is also caught when memory is read back at the end of each scenario.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
    localparam int CFG_W     = 16;
    localparam int REG_SEL_W = 2;
    localparam int TRIG_N    = 4;
    localparam int TSEL_W    = $clog2(TRIG_N);

    localparam logic [REG_SEL_W-1:0] REG_SRC  = 2'd0;
    localparam logic [REG_SEL_W-1:0] REG_DST  = 2'd1;
    localparam logic [REG_SEL_W-1:0] REG_SIZE = 2'd2;
    localparam logic [REG_SEL_W-1:0] REG_CTRL = 2'd3;

    localparam int CTL_EN      = 0;
    localparam int CTL_IRQ_CLR = 15;

    typedef enum logic [1:0] {
        KIND_SINGLE = 2'd0,
        KIND_BLOCK  = 2'd1,
        KIND_BURST  = 2'd2,
        KIND_RSVD   = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_RSVD = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_GAP
    } fsm_e;

    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        step_e             dst_step;
        step_e             src_step;
        logic              word;
        logic              rpt;
        xfer_kind_e        kind;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CFG_W-1:0] w);
        ctrl_t c;
        c.kind     = xfer_kind_e'(w[2:1]);
        c.rpt      = w[3];
        c.word     = w[4];
        c.src_step = step_e'(w[6:5]);
        c.dst_step = step_e'(w[8:7]);
        c.tsel     = w[9 +: TSEL_W];
        return c;
    endfunction
endpackage

// File: rtl/dma_regs.sv
`timescale 1ns/1ps
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 pass_done,
    output logic [ADDR_W-1:0]    prog_src,
    output logic [ADDR_W-1:0]    prog_dst,
    output logic [CNT_W-1:0]     prog_size,
    output ctrl_t                cfg,
    output logic                 en,
    output logic                 irq,
    output logic                 arm
);
    logic ctl_wr;
    logic unused_bits;

    assign ctl_wr      = cfg_we && (cfg_sel == REG_CTRL);
    assign arm         = ctl_wr && cfg_wdata[CTL_EN] && !en;
    assign unused_bits = ^cfg_wdata[14:11];

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_src  <= '0;
            prog_dst  <= '0;
            prog_size <= '0;
            cfg       <= '0;
            en        <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel == REG_SRC)  prog_src  <= cfg_wdata[ADDR_W-1:0];
            if (cfg_we && cfg_sel == REG_DST)  prog_dst  <= cfg_wdata[ADDR_W-1:0];
            if (cfg_we && cfg_sel == REG_SIZE) prog_size <= cfg_wdata[CNT_W-1:0];
            if (ctl_wr) cfg <= decode_ctrl(cfg_wdata);

            if (ctl_wr)                      en <= cfg_wdata[CTL_EN];
            else if (pass_done && !cfg.rpt)  en <= 1'b0;

            if (ctl_wr && cfg_wdata[CTL_IRQ_CLR]) irq <= 1'b0;
            else if (pass_done)                   irq <= 1'b1;
        end
    end

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        irq && !(ctl_wr && cfg_wdata[CTL_IRQ_CLR]) |=> irq);

    // R3
    en_drop_chk: assert property (@(posedge clk) disable iff (rst)
        pass_done && !cfg.rpt && !ctl_wr |=> !en);
endmodule

// File: rtl/dma_trig.sv
`timescale 1ns/1ps
module dma_trig #(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     trig,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    logic cur;
    logic prev;

    assign cur   = trig[sel];
    assign pulse = cur && !prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= cur;
    end

    // R9
    edge_once_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/dma_addr_gen.sv
`timescale 1ns/1ps
module dma_addr_gen
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  step_e             step,
    input  logic              word,
    output logic [ADDR_W-1:0] q
);
    logic [ADDR_W-1:0] unit;

    assign unit = word ? ADDR_W'(2) : ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (adv) begin
            case (step)
                STEP_INC: q <= q + unit;
                STEP_DEC: q <= q - unit;
                default:  q <= q;
            endcase
        end
    end

    // R8
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        adv && !load && step == STEP_INC |=> q == $past(q) + $past(unit));

    // R8
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        adv && !load && (step == STEP_HOLD || step == STEP_RSVD) |=> $stable(q));
endmodule

// File: rtl/dma_fsm.sv
`timescale 1ns/1ps
module dma_fsm
    import dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pulse,
    input  logic             arm,
    input  xfer_kind_e       kind,
    input  logic             rpt,
    input  logic [CNT_W-1:0] prog_size,
    output logic             rd_cyc,
    output logic             wr_cyc,
    output logic             pass_done
);
    fsm_e             st, nx;
    logic [CNT_W-1:0] cnt;
    logic             odd;
    logic             last;

    assign last      = (cnt == CNT_W'(1));
    assign rd_cyc    = (st == ST_READ);
    assign wr_cyc    = (st == ST_WRITE);
    assign pass_done = wr_cyc && last;

    always_comb begin
        nx = st;
        case (st)
            ST_IDLE:  if (en && pulse) nx = ST_READ;
            ST_READ:  nx = ST_WRITE;
            ST_WRITE: begin
                if (last)                     nx = (rpt && kind == KIND_BURST) ? ST_GAP : ST_IDLE;
                else if (kind == KIND_BLOCK)  nx = ST_READ;
                else if (kind == KIND_BURST)  nx = odd ? ST_GAP : ST_READ;
                else                          nx = ST_IDLE;
            end
            ST_GAP:   nx = en ? ST_READ : ST_IDLE;
            default:  nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            odd <= 1'b0;
        end else begin
            st <= nx;
            if (arm || (pass_done && rpt)) cnt <= prog_size;
            else if (wr_cyc)               cnt <= cnt - 1'b1;
            if (st == ST_IDLE)  odd <= 1'b0;
            else if (wr_cyc)    odd <= last ? 1'b0 : !odd;
        end
    end

    logic [2:0] busy_run;
    always_ff @(posedge clk) begin
        if (rst)                    busy_run <= '0;
        else if (rd_cyc || wr_cyc)  busy_run <= (busy_run == 3'd7) ? busy_run : busy_run + 1'b1;
        else                        busy_run <= '0;
    end

    // R6
    burst_release_chk: assert property (@(posedge clk) disable iff (rst)
        kind == KIND_BURST && (rd_cyc || wr_cyc) |-> busy_run < 3'd4);

    // R4
    block_backtoback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cyc && kind == KIND_BLOCK && !last |=> rd_cyc);

    // R3
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE && !en |=> st == ST_IDLE);
endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
module dma_chan
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [TRIG_N-1:0]    trig,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic                 bus_byte,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_wdata,
    input  logic [DATA_W-1:0]    bus_rdata,
    output logic                 ch_en,
    output logic                 irq
);
    localparam int NUM_PTR = 2;

    logic [ADDR_W-1:0] prog_src, prog_dst;
    logic [CNT_W-1:0]  prog_size;
    ctrl_t             cfg;
    logic              en, arm, pulse;
    logic              rd_cyc, wr_cyc, pass_done, load_w;
    logic [ADDR_W-1:0] ptr_init [NUM_PTR];
    logic [ADDR_W-1:0] ptr_q    [NUM_PTR];
    step_e             ptr_step [NUM_PTR];

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pass_done(pass_done),
        .prog_src(prog_src), .prog_dst(prog_dst), .prog_size(prog_size),
        .cfg(cfg), .en(en), .irq(irq), .arm(arm)
    );

    dma_trig #(.N(TRIG_N), .SEL_W(TSEL_W)) u_trig (
        .clk(clk), .rst(rst), .trig(trig), .sel(cfg.tsel), .pulse(pulse)
    );

    dma_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .en(en), .pulse(pulse), .arm(arm),
        .kind(cfg.kind), .rpt(cfg.rpt), .prog_size(prog_size),
        .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .pass_done(pass_done)
    );

    assign load_w      = arm || (pass_done && cfg.rpt);
    assign ptr_init[0] = prog_src;
    assign ptr_init[1] = prog_dst;
    assign ptr_step[0] = cfg.src_step;
    assign ptr_step[1] = cfg.dst_step;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        dma_addr_gen #(.ADDR_W(ADDR_W)) u_ptr (
            .clk(clk), .rst(rst), .load(load_w), .load_val(ptr_init[g]),
            .adv(wr_cyc), .step(ptr_step[g]), .word(cfg.word), .q(ptr_q[g])
        );
    end

    assign bus_req   = rd_cyc || wr_cyc;
    assign bus_we    = wr_cyc;
    assign bus_byte  = !cfg.word;
    assign bus_addr  = wr_cyc ? ptr_q[1] : ptr_q[0];
    assign bus_wdata = cfg.word ? bus_rdata : {{(DATA_W-8){1'b0}}, bus_rdata[7:0]};
    assign ch_en     = en;

    // R1
    we_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> bus_req);

    // R2
    write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_we |=> bus_req && bus_we);
endmodule

// File: tb/test_dma_chan.sv
`timescale 1ns/1ps
module test_dma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  trig = '0;
    logic        bus_req, bus_we, bus_byte, ch_en, irq;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;

    always #5 clk = ~clk;

    dma_chan i_dma_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .trig(trig), .bus_req(bus_req),
        .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en), .irq(irq)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: byte array, read data one cycle after request
    logic [7:0]  mem [0:255];
    logic [15:0] rdata_q = '0;
    assign bus_rdata = rdata_q;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    function automatic logic [15:0] mread(input logic [15:0] a, input int w);
        if (w != 0) return {mem[{a[7:1], 1'b1}], mem[{a[7:1], 1'b0}]};
        return {8'h00, mem[a[7:0]]};
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    end

    always @(posedge clk) begin
        if (bus_req && !bus_we) rdata_q <= mread(bus_addr, bus_byte ? 0 : 1);
        if (bus_req && bus_we) begin
            if (bus_byte) mem[bus_addr[7:0]] = bus_wdata[7:0];
            else begin
                mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
                mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
            end
        end
    end

    // behavioural reference model
    int          m_phase;
    bit          m_en, m_irq, m_prev, m_odd;
    logic [15:0] m_src, m_dst, m_cnt, m_val;
    logic [15:0] p_src, p_dst, p_size;
    int          p_kind, p_rpt, p_word, p_ss, p_ds, p_tsel;

    function automatic logic [15:0] mstep(input logic [15:0] a, input int s, input int w);
        int d = (w != 0) ? 2 : 1;
        if (s == 1) return a + 16'(d);
        if (s == 2) return a - 16'(d);
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_en = 0; m_irq = 0; m_prev = 0; m_odd = 0;
            m_src = 0; m_dst = 0; m_cnt = 0; m_val = 0;
            p_src = 0; p_dst = 0; p_size = 0;
            p_kind = 0; p_rpt = 0; p_word = 0; p_ss = 0; p_ds = 0; p_tsel = 0;
        end else begin
            bit en_before, sel_now, pulse, last, old_odd;
            en_before = m_en;
            sel_now   = trig[p_tsel];
            pulse     = sel_now && !m_prev;
            m_prev    = sel_now;
            case (m_phase)
                0: begin
                    m_odd = 0;
                    if (m_en && pulse) m_phase = 1;
                end
                1: begin
                    m_val   = mread(m_src, p_word);
                    m_phase = 2;
                end
                2: begin
                    last    = (m_cnt == 16'd1);
                    old_odd = m_odd;
                    m_odd   = last ? 1'b0 : !old_odd;
                    if (last && p_rpt != 0) begin
                        m_src = p_src; m_dst = p_dst; m_cnt = p_size;
                    end else begin
                        m_src = mstep(m_src, p_ss, p_word);
                        m_dst = mstep(m_dst, p_ds, p_word);
                        m_cnt = m_cnt - 16'd1;
                    end
                    if (last) begin
                        m_irq = 1;
                        if (p_rpt == 0) m_en = 0;
                        m_phase = (p_rpt != 0 && p_kind == 2) ? 3 : 0;
                    end else if (p_kind == 1) m_phase = 1;
                    else if (p_kind == 2)     m_phase = old_odd ? 3 : 1;
                    else                      m_phase = 0;
                end
                default: m_phase = m_en ? 1 : 0;
            endcase
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: p_src  = cfg_wdata;
                    2'd1: p_dst  = cfg_wdata;
                    2'd2: p_size = cfg_wdata;
                    default: begin
                        if (cfg_wdata[15]) m_irq = 0;
                        if (cfg_wdata[0] && !en_before) begin
                            m_src = p_src; m_dst = p_dst; m_cnt = p_size;
                        end
                        m_en   = cfg_wdata[0];
                        p_kind = int'(cfg_wdata[2:1]);
                        p_rpt  = int'(cfg_wdata[3]);
                        p_word = int'(cfg_wdata[4]);
                        p_ss   = int'(cfg_wdata[6:5]);
                        p_ds   = int'(cfg_wdata[8:7]);
                        p_tsel = int'(cfg_wdata[10:9]);
                    end
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_req;
            exp_req = (m_phase == 1 || m_phase == 2);
            chk(cur_req, "bus_req", 32'(bus_req), 32'(exp_req));
            if (exp_req) begin
                chk(cur_req, "bus_we", 32'(bus_we), 32'(m_phase == 2));
                chk(cur_req, "bus_addr", 32'(bus_addr), 32'((m_phase == 2) ? m_dst : m_src));
                chk(cur_req, "bus_byte", 32'(bus_byte), 32'(p_word == 0));
                if (m_phase == 2) chk(cur_req, "bus_wdata", 32'(bus_wdata), 32'(m_val));
            end
            chk(cur_req, "ch_en", 32'(ch_en), 32'(m_en));
            chk(cur_req, "irq", 32'(irq), 32'(m_irq));
        end
    end

    task automatic wcfg(input logic [1:0] s, input logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input int line, input int hi, input int lo);
        trig[line] = 1'b1;
        idle(hi);
        trig[line] = 1'b0;
        idle(lo);
    endtask

    function automatic logic [15:0] ctl(input int kind, input int rpt, input int word,
                                        input int ss, input int ds, input int tsel);
        return 16'(1 | (kind << 1) | (rpt << 3) | (word << 4) | (ss << 5) | (ds << 7) | (tsel << 9));
    endfunction

    function automatic logic [15:0] pword(input int a);
        return {pat(a + 1), pat(a)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "bus_req after reset", 32'(bus_req), 0);
        chk("R1", "ch_en after reset", 32'(ch_en), 0);
        chk("R1", "irq after reset", 32'(irq), 0);

        // R2 single byte transfers, increment both
        cur_req = "R2";
        wcfg(2'd0, 16'h0010); wcfg(2'd1, 16'h0080); wcfg(2'd2, 16'd3);
        wcfg(2'd3, ctl(0, 0, 0, 1, 1, 1));
        idle(2);
        for (int k = 0; k < 3; k++) fire(1, 1, 5);
        chk("R2", "ch_en after count", 32'(ch_en), 0);
        chk("R2", "irq after count", 32'(irq), 1);
        for (int k = 0; k < 3; k++) chk("R2", "dst byte", 32'(mem[8'h80 + k]), 32'(pat(16 + k)));
        // R3 trigger after auto-disable is ignored
        cur_req = "R3";
        fire(1, 1, 5);
        chk("R3", "no extra byte", 32'(mem[8'h83]), 32'(pat(8'h83)));
        // R10 sticky flag
        cur_req = "R10";
        wcfg(2'd3, 16'h0000);
        idle(2);
        chk("R10", "irq survives plain write", 32'(irq), 1);
        wcfg(2'd3, 16'h8000);
        chk("R10", "irq cleared", 32'(irq), 0);

        // R9 select and edge rules, repeated single word
        cur_req = "R9";
        wcfg(2'd0, 16'h0020); wcfg(2'd1, 16'h0090); wcfg(2'd2, 16'd2);
        wcfg(2'd3, ctl(0, 1, 1, 1, 1, 2));
        idle(2);
        fire(0, 1, 5);
        chk("R9", "unselected line ignored", 32'({mem[8'h91], mem[8'h90]}), 32'(pword(8'h90)));
        fire(2, 8, 5);
        chk("R9", "held level one unit", 32'({mem[8'h91], mem[8'h90]}), 32'(pword(8'h20)));
        chk("R9", "held level no second unit", 32'({mem[8'h93], mem[8'h92]}), 32'(pword(8'h92)));
        trig[2] = 1'b1; idle(1); trig[2] = 1'b0; idle(1); trig[2] = 1'b1; idle(1); trig[2] = 1'b0;
        idle(5);
        chk("R9", "busy edge ignored", 32'({mem[8'h93], mem[8'h92]}), 32'(pword(8'h22)));
        cur_req = "R5";
        chk("R5", "enable persists", 32'(ch_en), 1);
        chk("R5", "irq on reload", 32'(irq), 1);
        fire(2, 1, 5);
        chk("R5", "reloaded address used", 32'({mem[8'h95], mem[8'h94]}), 32'(pword(8'h94)));
        wcfg(2'd3, 16'h8000);

        // R4 block of words, destination decrements (R8)
        cur_req = "R4";
        wcfg(2'd0, 16'h0040); wcfg(2'd1, 16'h00C0); wcfg(2'd2, 16'd4);
        wcfg(2'd3, ctl(1, 0, 1, 1, 2, 0));
        idle(2);
        fire(0, 1, 12);
        chk("R4", "block ends disabled", 32'(ch_en), 0);
        for (int k = 0; k < 4; k++)
            chk("R8", "word step", 32'({mem[8'hC1 - 2 * k], mem[8'hC0 - 2 * k]}), 32'(pword(8'h40 + 2 * k)));
        wcfg(2'd3, 16'h8000);

        // R6 burst-block, bytes
        cur_req = "R6";
        wcfg(2'd0, 16'h0050); wcfg(2'd1, 16'h00D0); wcfg(2'd2, 16'd5);
        wcfg(2'd3, ctl(2, 0, 0, 1, 1, 3));
        idle(2);
        fire(3, 1, 16);
        chk("R6", "burst ends disabled", 32'(ch_en), 0);
        for (int k = 0; k < 5; k++) chk("R6", "burst byte", 32'(mem[8'hD0 + k]), 32'(pat(8'h50 + k)));
        wcfg(2'd3, 16'h8000);

        // R7 repeated burst-block runs until enable is cleared
        cur_req = "R7";
        wcfg(2'd0, 16'h0060); wcfg(2'd1, 16'h00E0); wcfg(2'd2, 16'd3);
        wcfg(2'd3, ctl(2, 1, 0, 1, 1, 3));
        idle(2);
        fire(3, 1, 30);
        chk("R7", "still enabled", 32'(ch_en), 1);
        wcfg(2'd3, ctl(2, 1, 0, 1, 1, 3) & 16'hFFFE);
        idle(10);
        chk("R7", "bus quiet after stop", 32'(bus_req), 0);
        for (int k = 0; k < 3; k++) chk("R7", "pass byte", 32'(mem[8'hE0 + k]), 32'(pat(8'h60 + k)));
        chk("R7", "no overrun", 32'(mem[8'hE3]), 32'(pat(8'hE3)));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL %s watchdog: actual hung expected finished", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule